// File: doc/BRIEF.md
# Segmented-Tree Mismatch-Shaping Encoder

This block turns a 7-bit unsigned feedback code into the drive pattern for a capacitive feedback DAC. The DAC has mismatched unit elements. The block spreads the code over those elements in a pseudo-random way, so that element errors raise the noise floor a little instead of producing harmonic distortion or idle tones.

The three least significant code bits are passed straight to three binary-weighted lines of weights 4, 2 and 1. The upper four bits give a count of coarse elements, each of weight 8. That count enters a four-level binary tree of switching nodes. Each node splits its count between its two subtrees. When the count is odd, the extra unit goes to the upper or the lower subtree according to one bit from a free-running 16-bit maximal-length LFSR. The 16 leaves of the tree drive 16 coarse lines, so the DAC needs only 16 coarse wires. A rotation scheme over unit elements would need 128.

A sample is taken on each clock edge where the sample strobe is high. All output lines are registered and change together on that edge. The LFSR steps once per sample.

Top module: `seg_tree_dem`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every coarse line and every binary line reads 0.
- R2: One clock after a sample, the binary lines show the three least significant code bits: bit 2 is weight 4, bit 1 is weight 2, bit 0 is weight 1.
- R3: One clock after a sample, the number of asserted coarse lines equals code bits 6..3 read as an unsigned number, whatever the random choices are.
- R4: A code of 0 asserts no lines at all. A code of 127 asserts 15 coarse lines and all three binary lines.
- R5: On a clock edge with the sample strobe low, every output line keeps its value, even if the code input changes.
- R6: The selection changes from sample to sample. Over 64 consecutive samples whose upper value is 1, at least four different coarse lines are driven.
- R7: Let the lower half be coarse lines 7..0 and the upper half be lines 15..8. The asserted counts in the two halves differ by at most one. When the upper value is even, the two counts are equal.
- R8: The random source never holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | Sample strobe: the code is taken on each rising edge where this is high |
| code_in | input | 7 | Unsigned feedback code |
| coarse_q | output | 16 | Coarse element lines, each of weight 8 |
| lsb_q | output | 3 | Binary lines of weights 4, 2 and 1 |

## Verification
The assertions rely on two things about the inputs. The code input is a fully defined value at every sampling edge. The upper code field never exceeds the number of coarse elements, which holds by construction: four bits reach at most 15 and there are 16 elements. They also rely on the strobe being a clean level that is sampled on the edge. The bench changes the code and the strobe only on the falling clock edge, so every sample sees a settled value. The bench drives every upper value from 0 to 15 and mixes odd and even counts, so that every tree node takes a random split at least once.

// File: rtl/dem_pkg.sv
package dem_pkg;

   // Feedback tap mask for a Fibonacci LFSR of the given width.
   // Only widths the block supports return a non-zero mask.
   function automatic logic [31:0] lfsr_taps(input int unsigned width);
      logic [31:0] m;
      m = '0;
      case (width)
         16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3]  = 1'b1; end
         24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
         32: begin m[31] = 1'b1; m[21] = 1'b1; m[1]  = 1'b1; m[0]  = 1'b1; end
         default: m = '0;
      endcase
      return m;
   endfunction

   function automatic bit width_supported(input int unsigned width);
      return (width == 16) || (width == 24) || (width == 32);
   endfunction

endpackage

// File: rtl/dem_lfsr.sv
module dem_lfsr
   import dem_pkg::*;
#(
   parameter int unsigned        WIDTH = 16,
   parameter logic [WIDTH-1:0]   SEED  = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [WIDTH-1:0] state
);
   localparam logic [31:0] TAPS = lfsr_taps(WIDTH);

   if (!width_supported(WIDTH)) begin : g_bad_width
      $error("dem_lfsr: unsupported WIDTH %0d", WIDTH);
   end
   if (SEED == '0) begin : g_bad_seed
      $error("dem_lfsr: SEED must be non-zero");
   end

   logic fb;
   assign fb = ^(state & TAPS[WIDTH-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state <= SEED;
      else if (step)  state <= {state[WIDTH-2:0], fb};
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0); // R8

endmodule

// File: rtl/dem_split_node.sv
module dem_split_node #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             pick_hi,
   output logic [CNT_W-1:0] hi,
   output logic [CNT_W-1:0] lo
);
   logic [CNT_W-1:0] half;
   logic             odd;

   always_comb begin
      half = cnt >> 1;
      odd  = cnt[0];
      hi   = half + {{(CNT_W-1){1'b0}}, odd &  pick_hi};
      lo   = half + {{(CNT_W-1){1'b0}}, odd & ~pick_hi};
   end

   AST_SPLIT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W+1)'(hi) + (CNT_W+1)'(lo) == (CNT_W+1)'(cnt)); // R3
   AST_SPLIT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (hi == lo) || (hi == lo + 1'b1) || (lo == hi + 1'b1)); // R7

endmodule

// File: rtl/dem_tree.sv
module dem_tree #(
   parameter int unsigned LEVELS = 4,
   localparam int unsigned LEAVES = 1 << LEVELS,
   localparam int unsigned NODES  = LEAVES - 1,
   localparam int unsigned CNT_W  = LEVELS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-1:0] count,
   input  logic [NODES-1:0]  rnd,
   output logic [LEAVES-1:0] lines
);
   // Heap layout: index 1 is the root, the children of index i are 2i and
   // 2i+1, and indices LEAVES .. 2*LEAVES-1 are the leaves.
   logic [CNT_W-1:0] cnt [1:2*LEAVES-1];

   assign cnt[1] = {1'b0, count};

   for (genvar i = 1; i <= NODES; i++) begin : g_node
      dem_split_node #(.CNT_W(CNT_W)) u_node (
         .clk     (clk),
         .rst_n   (rst_n),
         .cnt     (cnt[i]),
         .pick_hi (rnd[i-1]),
         .hi      (cnt[2*i+1]),
         .lo      (cnt[2*i])
      );
   end

   for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      assign lines[j] = |cnt[LEAVES+j];
   end

endmodule

// File: rtl/seg_tree_dem.sv
module seg_tree_dem #(
   parameter int unsigned      CODE_W    = 7,
   parameter int unsigned      BIN_W     = 3,
   parameter int unsigned      LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   localparam int unsigned     LEVELS    = CODE_W - BIN_W,
   localparam int unsigned     COARSE_N  = 1 << LEVELS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                samp_en,
   input  logic [CODE_W-1:0]   code_in,
   output logic [COARSE_N-1:0] coarse_q,
   output logic [BIN_W-1:0]    lsb_q
);
   localparam int unsigned NODES = COARSE_N - 1;

   if (CODE_W <= BIN_W) begin : g_bad_split
      $error("seg_tree_dem: CODE_W must exceed BIN_W");
   end
   if (LFSR_W < NODES) begin : g_bad_lfsr
      $error("seg_tree_dem: LFSR_W must supply one bit per tree node");
   end

   logic [LFSR_W-1:0]   lfsr_state;
   logic [COARSE_N-1:0] tree_lines;
   logic [LEVELS-1:0]   upper;

   assign upper = code_in[CODE_W-1:BIN_W];

   dem_lfsr #(.WIDTH(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (samp_en),
      .state (lfsr_state)
   );

   dem_tree #(.LEVELS(LEVELS)) u_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .count (upper),
      .rnd   (lfsr_state[NODES-1:0]),
      .lines (tree_lines)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= '0;
         lsb_q    <= '0;
      end else if (samp_en) begin
         coarse_q <= tree_lines;
         lsb_q    <= code_in[BIN_W-1:0];
      end
   end

   AST_COARSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      samp_en |=> $countones(coarse_q) == int'($past(upper))); // R3
   AST_LSB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      samp_en |=> lsb_q == $past(code_in[BIN_W-1:0])); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en |=> $stable(coarse_q) && $stable(lsb_q)); // R5
   AST_HALF_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(coarse_q[COARSE_N-1:COARSE_N/2]) <= $countones(coarse_q[COARSE_N/2-1:0]) + 1) &&
      ($countones(coarse_q[COARSE_N/2-1:0]) <= $countones(coarse_q[COARSE_N-1:COARSE_N/2]) + 1)); // R7

endmodule

// File: tb/seg_tree_dem_tb.sv
module seg_tree_dem_tb;
   localparam int CLK_NS = 20;
   localparam int WATCHDOG_CYC = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        samp_en = 1'b0;
   logic [6:0]  code_in = '0;
   logic [15:0] coarse_q;
   logic [2:0]  lsb_q;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   seg_tree_dem u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_en  (samp_en),
      .code_in  (code_in),
      .coarse_q (coarse_q),
      .lsb_q    (lsb_q)
   );

   always #(CLK_NS/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG_CYC && !done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG_CYC);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Sample one code: drive it on the falling edge, let one rising edge
   // take it, and return on the next falling edge, when the outputs are valid.
   task automatic sample(input logic [6:0] c);
      code_in = c;
      samp_en = 1'b1;
      @(negedge clk);
      samp_en = 1'b0;
   endtask

   localparam int NVEC = 14;
   localparam logic [6:0] VEC [NVEC] = '{
      7'd0, 7'd1, 7'd8, 7'd15, 7'd16, 7'd37, 7'd64,
      7'd85, 7'd100, 7'd119, 7'd120, 7'd127, 7'd58, 7'd73
   };

   initial begin
      int lo_cnt;
      int hi_cnt;
      int up;
      logic [15:0] seen;
      logic [15:0] held_c;
      logic [2:0]  held_l;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(coarse_q == '0, "R1 coarse in reset", coarse_q, 0);
      check(lsb_q == '0, "R1 lsb in reset", lsb_q, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(coarse_q == '0 && lsb_q == '0, "R1 after release", {coarse_q, lsb_q}, 0);

      // Table walk: R2, R3, R7
      for (int i = 0; i < NVEC; i++) begin
         sample(VEC[i]);
         up = int'(VEC[i][6:3]);
         check(lsb_q == VEC[i][2:0], "R2 binary lines", lsb_q, VEC[i][2:0]);
         check($countones(coarse_q) == up, "R3 coarse count", $countones(coarse_q), up);
         lo_cnt = $countones(coarse_q[7:0]);
         hi_cnt = $countones(coarse_q[15:8]);
         if (up % 2 == 0)
            check(lo_cnt == hi_cnt, "R7 even halves equal", hi_cnt, lo_cnt);
         else
            check((lo_cnt - hi_cnt == 1) || (hi_cnt - lo_cnt == 1),
                  "R7 odd halves differ by one", hi_cnt, lo_cnt);
      end

      // R3 across every upper value, twice each
      for (int k = 0; k < 32; k++) begin
         sample(7'((k % 16) * 8 + (k % 8)));
         check($countones(coarse_q) == k % 16, "R3 sweep", $countones(coarse_q), k % 16);
      end

      // R4: extremes
      sample(7'd0);
      check(coarse_q == '0 && lsb_q == '0, "R4 zero code", {coarse_q, lsb_q}, 0);
      sample(7'd127);
      check($countones(coarse_q) == 15, "R4 full code coarse", $countones(coarse_q), 15);
      check(lsb_q == 3'b111, "R4 full code binary", lsb_q, 7);

      // R5: hold while strobe low
      sample(7'd93);
      held_c = coarse_q;
      held_l = lsb_q;
      code_in = 7'd22;
      repeat (4) @(negedge clk);
      check(coarse_q == held_c, "R5 coarse held", coarse_q, held_c);
      check(lsb_q == held_l, "R5 binary held", lsb_q, held_l);

      // R6: selection varies over time
      seen = '0;
      for (int k = 0; k < 64; k++) begin
         sample(7'd8);
         seen |= coarse_q;
      end
      check($countones(seen) >= 4, "R6 distinct lines", $countones(seen), 4);

      // R1: reset in mid-run clears outputs
      sample(7'd111);
      rst_n = 1'b0;
      @(negedge clk);
      check(coarse_q == '0 && lsb_q == '0, "R1 mid-run reset", {coarse_q, lsb_q}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: the random source keeps producing splits after reset
      sample(7'd9);
      check($countones(coarse_q) == 1, "R8 source alive after reset", $countones(coarse_q), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule